// File: doc/BRIEF.md
# Linked-Pair Buffered PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter that wraps at a programmable period value. The pulse width is taken from one of two compare registers. In plain mode only compare register A is used, and writes to it act at once. In linked mode the two registers take turns: the register written most recently becomes the active width source, but only when the counter next wraps. Software can therefore prepare the next width in the idle register without disturbing the current period.

A single synchronous write port loads four words: control, period, compare A and compare B. The control word holds a stop bit, a self-clearing counter-clear bit and the link bit. The outputs are the PWM pin, a one-cycle wrap strobe, and a flag saying that the second channel's pin is free for general-purpose use.

Source selection is a three-state machine:
- SRC_PLAIN: link off, A drives the output.
- SRC_USE_A: linked, A active.
- SRC_USE_B: linked, B active.

Its transitions are:
- enter_link: SRC_PLAIN to SRC_USE_A, when the link bit is seen set.
- swap_to_b: SRC_USE_A to SRC_USE_B, at a wrap when B was written last.
- swap_to_a: SRC_USE_B to SRC_USE_A, at a wrap when A was written last.
- leave_link: from either linked state to SRC_PLAIN, when the link bit is clear.

Top module: `bpwm_top`

## Requirements
- R1: After reset the period is 0xFFFF, both compare registers are 0, and stop and link are 0. pwm_out, ovf_pulse and chb_pin_free are 0, and the counter starts at 0 and runs.
- R2: Word addresses are 0 control, 1 period, 2 compare A and 3 compare B. While running, the counter steps by one per clock. In the clock after it holds a value greater than or equal to the period, it becomes 0. ovf_pulse is high for exactly that one cycle, while the counter reads 0.
- R3: Control bit 0 (stop) set freezes the counter. No wrap or ovf_pulse occurs while it is set.
- R4: Writing control with bit 1 set clears the counter to 0 on that clock. This takes priority over counting and stopping, and it is not a wrap: no ovf_pulse, no source change.
- R5: pwm_out is high while the counter is below the active compare value and low otherwise. A compare value above the period gives a constant high; a value of 0 gives a constant low.
- R6: With control bit 2 (link) clear, compare A is the only source and writes to compare B have no effect on pwm_out.
- R7: chb_pin_free equals the stored link bit. When link is turned on, compare A is the active source first.
- R8: In linked mode, a write to the idle register B does not change pwm_out in the current period. B becomes active from the next wrap.
- R9: At every wrap in linked mode, the active source becomes whichever of A or B was written last. A write in the same cycle as a wrap counts toward the period after the next one.
- R10: A write to the currently active compare register takes effect from the next cycle, within the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address (0 control, 1 period, 2 compare A, 3 compare B) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |
| ovf_pulse | output | 1 | One-cycle strobe in the cycle after a wrap |
| chb_pin_free | output | 1 | Second channel pin released (link mode) |

## Verification
A write sampled at a clock edge is visible in the registers after that edge. pwm_out is a combinational compare of registered state, so it reflects a write or a count one cycle after the edge that took it in. ovf_pulse and a source swap appear in the same cycle, the first one after the wrapping edge, while the counter reads 0. The bench keeps a cycle model that advances on each rising edge from the same inputs the design sees. It compares all three outputs at every falling edge, before the next inputs are driven, so each result is checked in the cycle it is due. Directed phases place writes on, before and after wrap cycles, and a seeded random phase mixes period, compare and control writes.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] RA_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] RA_CMPA   = 2'd2;
    localparam logic [ADDR_W-1:0] RA_CMPB   = 2'd3;

    localparam int unsigned CTL_STOP = 0;
    localparam int unsigned CTL_CLR  = 1;
    localparam int unsigned CTL_LINK = 2;

    typedef enum logic [1:0] {
        SRC_PLAIN = 2'd0,
        SRC_USE_A = 2'd1,
        SRC_USE_B = 2'd2
    } src_state_e;
endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs import bpwm_pkg::*; #(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      period,
    output logic [W-1:0]      cmp_a,
    output logic [W-1:0]      cmp_b,
    output logic              stop,
    output logic              link,
    output logic              clr_cmd,
    output logic              ctl_wr,
    output logic              wr_a,
    output logic              wr_b
);
    logic per_wr;

    always_comb begin
        ctl_wr  = wr_en && (wr_addr == RA_CTRL);
        per_wr  = wr_en && (wr_addr == RA_PERIOD);
        wr_a    = wr_en && (wr_addr == RA_CMPA);
        wr_b    = wr_en && (wr_addr == RA_CMPB);
        clr_cmd = ctl_wr && wr_data[CTL_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '1;
            cmp_a  <= '0;
            cmp_b  <= '0;
            stop   <= 1'b0;
            link   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                stop <= wr_data[CTL_STOP];
                link <= wr_data[CTL_LINK];
            end
            if (per_wr) period <= wr_data;
            if (wr_a)   cmp_a  <= wr_data;
            if (wr_b)   cmp_b  <= wr_data;
        end
    end
endmodule

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop,
    input  logic         clr_cmd,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         ovf
);
    always_comb begin
        wrap = !stop && !clr_cmd && (cnt >= period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= wrap;
            if (clr_cmd || wrap) begin
                cnt <= '0;
            end else if (!stop) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpwm_srcsel.sv
module bpwm_srcsel import bpwm_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link,
    input  logic       wrap,
    input  logic       wr_a,
    input  logic       wr_b,
    output logic       use_b,
    output logic       pend_b,
    output src_state_e state
);
    src_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_PLAIN: if (link) state_nx = SRC_USE_A;
            SRC_USE_A: begin
                if (!link)               state_nx = SRC_PLAIN;
                else if (wrap && pend_b) state_nx = SRC_USE_B;
            end
            SRC_USE_B: begin
                if (!link)                state_nx = SRC_PLAIN;
                else if (wrap && !pend_b) state_nx = SRC_USE_A;
            end
            default: state_nx = SRC_PLAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_PLAIN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pend_b <= 1'b0;
        else if (!link) pend_b <= 1'b0;
        else if (wr_a)  pend_b <= 1'b0;
        else if (wr_b)  pend_b <= 1'b1;
    end

    always_comb begin
        use_b = (state == SRC_USE_B);
    end
endmodule

// File: rtl/bpwm_out.sv
module bpwm_out #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         use_b,
    output logic         pwm
);
    logic [W-1:0] act_val;

    always_comb begin
        act_val = use_b ? cmp_b : cmp_a;
        pwm     = (cnt < act_val);
    end
endmodule

// File: rtl/bpwm_top.sv
module bpwm_top import bpwm_pkg::*; #(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              ovf_pulse,
    output logic              chb_pin_free
);
    logic [CNT_W-1:0] period, cmp_a, cmp_b, cnt;
    logic stop, link, clr_cmd, ctl_wr, wr_a, wr_b, wrap, use_b, pend_b;
    src_state_e src_state;

    bpwm_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .stop(stop), .link(link), .clr_cmd(clr_cmd), .ctl_wr(ctl_wr),
        .wr_a(wr_a), .wr_b(wr_b)
    );

    bpwm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .stop(stop), .clr_cmd(clr_cmd),
        .period(period), .cnt(cnt), .wrap(wrap), .ovf(ovf_pulse)
    );

    bpwm_srcsel u_sel (
        .clk(clk), .rst_n(rst_n), .link(link), .wrap(wrap),
        .wr_a(wr_a), .wr_b(wr_b), .use_b(use_b), .pend_b(pend_b),
        .state(src_state)
    );

    bpwm_out #(.W(CNT_W)) u_out (
        .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b), .use_b(use_b), .pwm(pwm_out)
    );

    assign chb_pin_free = link;
endmodule

// File: rtl/bpwm_chk.sv
module bpwm_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic [W-1:0] period,
    input logic [W-1:0] cmp_a,
    input logic         stop,
    input logic         link,
    input logic         clr_cmd,
    input logic         wrap,
    input logic         use_b,
    input logic         ovf_pulse,
    input logic         pwm_out
);
    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt == '0)); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr_cmd) |=> (cnt == $past(cnt))); // R3
    AST_CLR_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> ((cnt == '0) && !ovf_pulse)); // R4
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_b && (cmp_a > period) && (cnt <= period)) |-> pwm_out); // R5
    AST_PLAIN_USES_A: assert property (@(posedge clk) disable iff (!rst_n)
        !link |=> !use_b); // R6
    AST_SWAP_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (link && !wrap) |=> (use_b == $past(use_b))); // R9
endmodule

bind bpwm_top bpwm_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .period(period), .cmp_a(cmp_a),
    .stop(stop), .link(link), .clr_cmd(clr_cmd), .wrap(wrap),
    .use_b(use_b), .ovf_pulse(ovf_pulse), .pwm_out(pwm_out)
);

// File: tb/tb_bpwm_top.sv
module tb_bpwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out, ovf_pulse, chb_pin_free;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    bpwm_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse),
        .chb_pin_free(chb_pin_free)
    );

    // reference model, advanced from the requirements
    logic [15:0] m_cnt, m_mod, m_a, m_b;
    logic        m_stop, m_link, m_ovf, m_pend;
    int          m_st; // 0 plain, 1 A active, 2 B active

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 16'hFFFF; m_a = 0; m_b = 0;
            m_stop = 0; m_link = 0; m_ovf = 0; m_pend = 0; m_st = 0;
        end else begin
            logic clr, wrp;
            int   st_n;
            logic pend_n;
            clr = wr_en && wr_addr == 2'd0 && wr_data[1];
            wrp = !m_stop && !clr && (m_cnt >= m_mod);
            st_n = m_st;
            if (!m_link) st_n = 0;
            else if (m_st == 0) st_n = 1;
            else if (wrp) st_n = m_pend ? 2 : 1;
            pend_n = m_pend;
            if (!m_link) pend_n = 0;
            else if (wr_en && wr_addr == 2'd2) pend_n = 0;
            else if (wr_en && wr_addr == 2'd3) pend_n = 1;
            m_ovf = wrp;
            if (clr || wrp) m_cnt = 0;
            else if (!m_stop) m_cnt = m_cnt + 16'd1;
            m_st = st_n;
            m_pend = pend_n;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_stop = wr_data[0]; m_link = wr_data[2]; end
                    2'd1: m_mod = wr_data;
                    2'd2: m_a = wr_data;
                    default: m_b = wr_data;
                endcase
            end
        end
    end

    function automatic logic exp_pwm();
        return m_cnt < ((m_st == 2) ? m_b : m_a);
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic sample();
        check(pwm_out, exp_pwm(), phase, "pwm_out");
        check(ovf_pulse, m_ovf, "R2", "ovf_pulse");
        check(chb_pin_free, m_link, "R7", "chb_pin_free");
    endtask

    task automatic step(input logic en, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cyc++;
        sample();
        wr_en = en; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'd0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        step(1'b1, a, d);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        phase = "R1"; idle(4);
        // R3 / R4: stop, clear, program period and width
        phase = "R3"; wr(2'd0, 16'h0001); idle(3);
        phase = "R4"; wr(2'd0, 16'h0003); wr(2'd1, 16'd9); wr(2'd2, 16'd4);
        phase = "R3"; idle(6);
        phase = "R2"; wr(2'd0, 16'h0000); idle(25);
        phase = "R4"; wr(2'd0, 16'h0002); idle(12);
        // R5 duty extremes
        phase = "R5"; wr(2'd2, 16'd15); idle(12);
        wr(2'd2, 16'd0); idle(12); wr(2'd2, 16'd4); idle(4);
        // R6 unlinked: B write has no effect
        phase = "R6"; wr(2'd3, 16'd7); idle(22);
        // R7 link on, A first
        phase = "R7"; wr(2'd0, 16'h0004); idle(12);
        // R8 buffered write to B
        phase = "R8"; wr(2'd3, 16'd7); idle(25);
        // R10 write to active register B
        phase = "R10"; wr(2'd3, 16'd2); idle(10);
        // R9 both written in one period, last wins
        phase = "R9"; wr(2'd2, 16'd6); wr(2'd3, 16'd8); idle(24);
        // R9 write on the wrap cycle
        while (!(m_cnt >= m_mod)) idle(1);
        wr(2'd2, 16'd3); idle(24);
        // random mix
        phase = "R5";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 16;
            if (r < 3) begin
                logic [1:0] a;
                logic [15:0] d;
                a = 2'($urandom % 4);
                case (a)
                    2'd0: d = {13'd0, 1'($urandom % 2), 1'(($urandom % 8) == 0), 1'(($urandom % 8) == 0)};
                    2'd1: d = 16'($urandom % 24);
                    default: d = 16'($urandom % 28);
                endcase
                wr(a, d);
            end else begin
                idle(1);
            end
        end
        idle(2);
        finish_run();
    end
endmodule